// File: doc/BRIEF.md
# Multi-mode video input capture

This block sits at the front of a video transmit path. It takes a 24-bit parallel pixel bus with separate DE, HSYNC and VSYNC pins and turns it into one normalized pixel stream. A run-time mode code picks how pixels arrive: full-width 4:4:4 on one clock edge, wide 4:2:2 with a full pixel per clock, narrow 4:2:2 split over two beats of a doubled pixel clock, or narrow 4:2:2 split over the two edges of one clock (DDR). A justification code tells the block where the narrow or wide components sit on the bus.

Each output pixel has three component fields of CW bits, a valid strobe, and the DE and sync levels that belong to that pixel. In the 4:2:2 modes the luma goes to component 0, the chroma sample of that pixel (Cb and Cr alternate from pixel to pixel) goes to component 1, and component 2 is zero. Configuration is taken only during blanking, so a line is never decoded half in one layout and half in another.

Top module: `vcap_top`

## Requirements
- R1: While rst_n is low, comp0_o, comp1_o, comp2_o, de_o, hs_o, vs_o and pix_vld_o are all zero.
- R2: Mode code 0 (full 4:4:4): bus bits [15:8] go to comp0_o, [7:0] go to comp1_o and [23:16] go to comp2_o. Each sits in the upper 8 bits of its CW-bit field with zeros below. One pixel comes out per clock, registered on the edge after capture.
- R3: Mode code 1 (wide 4:2:2): one Y and one chroma sample are taken per clock, to comp0_o and comp1_o, and comp2_o is zero. Justification code 1: chroma in bus[CW-1:0], Y in bus[2CW-1:CW]. Code 2: Y in bus[23:24-CW], chroma directly below it. Code 0: the upper 8 bits of Y in bus[15:8] and the upper 8 bits of chroma in bus[7:0]; the low CW-8 bits of Y in bus[23:32-CW] and the low bits of chroma directly beneath those. Code 3 acts as code 0.
- R4: In the narrow modes (codes 2 and 3) one CW-bit component is taken per beat. Justification code 1 uses bus[CW-1:0]. Code 2 uses bus[23:24-CW]. Code 0 puts the upper 8 bits in bus[15:8] and the low CW-8 bits in bus[23:32-CW].
- R5: Mode code 2 (doubled clock): the beat on which DE rises carries chroma and the next beat carries Y, and beats keep pairing in that order. The pixel is registered on the Y beat's edge, with the syncs of the Y beat.
- R6: Mode code 3 with ddr_rise_first_i=1: chroma is sampled on a rising edge and Y on the following falling edge. The pixel appears after the next rising edge.
- R7: Mode code 3 with ddr_rise_first_i=0: chroma is sampled on a falling edge and Y on the following rising edge. The pixel appears after the rising edge after that.
- R8: In mode code 3, de_o, hs_o and vs_o of a pixel are the levels sampled on that pixel's rising-edge half.
- R9: DE, HSYNC and VSYNC go through the same register delay as the pixel data. Each pixel's sync levels come out with its components, and each input pixel gives exactly one output with de_o high.
- R10: mode_i, just_i and ddr_rise_first_i are taken only at rising edges where de_i is low. A change made while de_i is high has no effect on the pixels of that line.
- R11: pix_vld_o is high on every clock in modes 0, 1 and 3. In mode 2 it is high on every second beat, during blanking as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel or beat clock; both edges are used in DDR mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Input mode code (0 full, 1 wide, 2 doubled clock, 3 DDR) |
| just_i | input | 2 | Bus layout code (0 even, 1 right, 2 left) |
| ddr_rise_first_i | input | 1 | DDR: 1 = chroma on the rising half, 0 = chroma on the falling half |
| bus_i | input | BUS_W | Parallel pixel data bus |
| de_i | input | 1 | Data enable |
| hs_i | input | 1 | Horizontal sync |
| vs_i | input | 1 | Vertical sync |
| comp0_o | output | CW | G in 4:4:4, Y in 4:2:2 |
| comp1_o | output | CW | B in 4:4:4, chroma in 4:2:2 |
| comp2_o | output | CW | R in 4:4:4, zero in 4:2:2 |
| de_o | output | 1 | Data enable aligned to the pixel |
| hs_o | output | 1 | Horizontal sync aligned to the pixel |
| vs_o | output | 1 | Vertical sync aligned to the pixel |
| pix_vld_o | output | 1 | Output fields were loaded on the last rising edge |

## Verification
The bench drives random component values and randomizes the sync levels inside active video, beat by beat and half by half. A layout, beat order or delay error therefore shows up as a wrong value, not a lucky match. Each layout code is run in the wide and both narrow modes. A design that swaps the even-layout lanes, or takes the low bits from the wrong lane, returns scrambled components. In the doubled-clock mode, a design that does not restart pairing at DE rise treats Y as chroma. In DDR mode, both lead orders are run: pairing the wrong halves gives components from neighbouring pixels, and taking DE from the falling half gives an extra or missing pixel. A mode change made in the middle of a line checks that the configuration is held until blanking. Counting pix_vld_o during blanking checks the strobe rate in each mode.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

  typedef enum logic [1:0] {
    MODE_FULL = 2'd0,
    MODE_WIDE = 2'd1,
    MODE_X2   = 2'd2,
    MODE_DDR  = 2'd3
  } vc_mode_e;

  typedef enum logic [1:0] {
    JUST_EVEN  = 2'd0,
    JUST_RIGHT = 2'd1,
    JUST_LEFT  = 2'd2,
    JUST_ALT   = 2'd3
  } vc_just_e;

  // which component a lane picker extracts
  localparam int SLOT_NARROW = 0;
  localparam int SLOT_WIDE_Y = 1;
  localparam int SLOT_WIDE_C = 2;

  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
  } vc_sync_t;

endpackage

// File: rtl/vcap_lane_pick.sv
module vcap_lane_pick
  import vcap_pkg::*;
#(
  parameter int BUS_W = 24,
  parameter int CW    = 12,
  parameter int SLOT  = SLOT_NARROW
) (
  input  logic [BUS_W-1:0] bus_i,
  input  vc_just_e         just_i,
  output logic [CW-1:0]    comp_o
);

  localparam int LANE_W = BUS_W / 3;
  localparam int XW     = CW - LANE_W;      // extra low bits beyond one lane
  localparam int TOP    = BUS_W - 1;
  // slice positions for each layout, chosen by the slot variant (R3, R4)
  localparam int R_MSB  = (SLOT == SLOT_WIDE_Y) ? 2*CW - 1 : CW - 1;
  localparam int L_MSB  = (SLOT == SLOT_WIDE_C) ? TOP - CW : TOP;
  localparam int E_MSB  = (SLOT == SLOT_WIDE_C) ? LANE_W - 1 : 2*LANE_W - 1;
  localparam int X_MSB  = (SLOT == SLOT_WIDE_C) ? TOP - XW : TOP;

  logic [CW-1:0] right_v;
  logic [CW-1:0] left_v;
  logic [CW-1:0] even_v;

  assign right_v = bus_i[R_MSB -: CW];
  assign left_v  = bus_i[L_MSB -: CW];

  generate
    if (XW > 0) begin : g_split
      // high byte in its own lane, remaining low bits in the top lane
      assign even_v = {bus_i[E_MSB -: LANE_W], bus_i[X_MSB -: XW]};
    end else begin : g_whole
      assign even_v = bus_i[E_MSB -: LANE_W];
    end
  endgenerate

  always_comb begin
    case (just_i)
      JUST_RIGHT: comp_o = right_v;
      JUST_LEFT:  comp_o = left_v;
      default:    comp_o = even_v;
    endcase
  end

endmodule

// File: rtl/vcap_x2_pair.sv
module vcap_x2_pair
  import vcap_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          de_i,
  input  logic [CW-1:0] comp_i,
  output logic          first_o,
  output logic          load_o,
  output logic [CW-1:0] chroma_o
);

  logic de_d;
  logic prev_first;
  logic de_rise;

  // a DE rising edge restarts the pairing on a chroma beat (R5)
  assign de_rise = de_i & ~de_d;
  assign first_o = de_rise | ~prev_first;
  assign load_o  = ~first_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_d       <= 1'b0;
      prev_first <= 1'b0;
      chroma_o   <= '0;
    end else begin
      de_d       <= de_i;
      prev_first <= first_o;
      if (first_o) chroma_o <= comp_i;
    end
  end

  AST_PAIR_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> first_o); // R5

endmodule

// File: rtl/vcap_ddr_merge.sv
module vcap_ddr_merge
  import vcap_pkg::*;
#(
  parameter int BUS_W = 24,
  parameter int CW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_i,
  input  vc_sync_t         sync_i,
  input  vc_just_e         just_i,
  input  logic             rise_first_i,
  output logic [CW-1:0]    y_o,
  output logic [CW-1:0]    c_o,
  output vc_sync_t         sync_o
);

  logic [BUS_W-1:0] rise_q;   // rising-edge half
  logic [BUS_W-1:0] fall_q;   // falling-edge half
  logic [BUS_W-1:0] fall_hold; // previous falling half, seen at the rising edge
  vc_sync_t         rise_sync_q;
  logic [BUS_W-1:0] c_raw;
  logic [BUS_W-1:0] y_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q      <= '0;
      rise_sync_q <= '0;
      fall_hold   <= '0;
    end else begin
      rise_q      <= bus_i;
      rise_sync_q <= sync_i;
      fall_hold   <= fall_q;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= bus_i;
  end

  // R6: rise then fall of the same clock; R7: fall of the previous clock then rise
  assign c_raw  = rise_first_i ? rise_q : fall_hold;
  assign y_raw  = rise_first_i ? fall_q : rise_q;
  assign sync_o = rise_sync_q;   // R8: syncs come from the rising half

  vcap_lane_pick #(.BUS_W(BUS_W), .CW(CW), .SLOT(SLOT_NARROW)) u_pick_c (
    .bus_i  (c_raw),
    .just_i (just_i),
    .comp_o (c_o)
  );

  vcap_lane_pick #(.BUS_W(BUS_W), .CW(CW), .SLOT(SLOT_NARROW)) u_pick_y (
    .bus_i  (y_raw),
    .just_i (just_i),
    .comp_o (y_o)
  );

endmodule

// File: rtl/vcap_top.sv
module vcap_top
  import vcap_pkg::*;
#(
  parameter int BUS_W = 24,
  parameter int CW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       just_i,
  input  logic             ddr_rise_first_i,
  input  logic [BUS_W-1:0] bus_i,
  input  logic             de_i,
  input  logic             hs_i,
  input  logic             vs_i,
  output logic [CW-1:0]    comp0_o,
  output logic [CW-1:0]    comp1_o,
  output logic [CW-1:0]    comp2_o,
  output logic             de_o,
  output logic             hs_o,
  output logic             vs_o,
  output logic             pix_vld_o
);

  localparam int LANE_W = BUS_W / 3;

  // ---------------- configuration, taken in blanking only (R10)
  vc_mode_e mode_q;
  vc_just_e just_q;
  logic     lead_q;
  logic     cfg_open;

  assign cfg_open = ~de_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_FULL;
      just_q <= JUST_EVEN;
      lead_q <= 1'b1;
    end else if (cfg_open) begin
      mode_q <= vc_mode_e'(mode_i);
      just_q <= vc_just_e'(just_i);
      lead_q <= ddr_rise_first_i;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    de_i |=> ($stable(mode_q) && $stable(just_q) && $stable(lead_q))); // R10

  // ---------------- component pickers on the live bus
  logic [CW-1:0] wide_y;
  logic [CW-1:0] wide_c;
  logic [CW-1:0] narrow_v;
  vc_sync_t      live_sync;

  assign live_sync = '{de: de_i, hs: hs_i, vs: vs_i};

  vcap_lane_pick #(.BUS_W(BUS_W), .CW(CW), .SLOT(SLOT_WIDE_Y)) u_pick_wy (
    .bus_i (bus_i), .just_i (just_q), .comp_o (wide_y)
  );
  vcap_lane_pick #(.BUS_W(BUS_W), .CW(CW), .SLOT(SLOT_WIDE_C)) u_pick_wc (
    .bus_i (bus_i), .just_i (just_q), .comp_o (wide_c)
  );
  vcap_lane_pick #(.BUS_W(BUS_W), .CW(CW), .SLOT(SLOT_NARROW)) u_pick_n (
    .bus_i (bus_i), .just_i (just_q), .comp_o (narrow_v)
  );

  // ---------------- doubled-clock pairing
  logic          x2_first;
  logic          x2_load;
  logic [CW-1:0] x2_chroma;

  vcap_x2_pair #(.CW(CW)) u_x2 (
    .clk      (clk),
    .rst_n    (rst_n),
    .de_i     (de_i),
    .comp_i   (narrow_v),
    .first_o  (x2_first),
    .load_o   (x2_load),
    .chroma_o (x2_chroma)
  );

  // ---------------- dual-edge merge
  logic [CW-1:0] ddr_y;
  logic [CW-1:0] ddr_c;
  vc_sync_t      ddr_sync;

  vcap_ddr_merge #(.BUS_W(BUS_W), .CW(CW)) u_ddr (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_i        (bus_i),
    .sync_i       (live_sync),
    .just_i       (just_q),
    .rise_first_i (lead_q),
    .y_o          (ddr_y),
    .c_o          (ddr_c),
    .sync_o       (ddr_sync)
  );

  // ---------------- output selection
  function automatic logic [CW-1:0] widen(input logic [LANE_W-1:0] v);
    logic [CW-1:0] t;
    t = '0;
    t[CW-1 -: LANE_W] = v;
    return t;
  endfunction

  logic [CW-1:0] nxt_c0;
  logic [CW-1:0] nxt_c1;
  logic [CW-1:0] nxt_c2;
  vc_sync_t      nxt_sync;
  logic          nxt_load;

  always_comb begin
    nxt_c2   = '0;
    nxt_sync = live_sync;
    nxt_load = 1'b1;
    case (mode_q)
      MODE_FULL: begin            // R2
        nxt_c0 = widen(bus_i[2*LANE_W-1 -: LANE_W]);
        nxt_c1 = widen(bus_i[LANE_W-1:0]);
        nxt_c2 = widen(bus_i[BUS_W-1 -: LANE_W]);
      end
      MODE_WIDE: begin            // R3
        nxt_c0 = wide_y;
        nxt_c1 = wide_c;
      end
      MODE_X2: begin              // R5
        nxt_c0   = narrow_v;
        nxt_c1   = x2_chroma;
        nxt_load = x2_load;
      end
      default: begin              // R6, R7, R8
        nxt_c0   = ddr_y;
        nxt_c1   = ddr_c;
        nxt_sync = ddr_sync;
      end
    endcase
  end

  // one shared output stage keeps syncs and data on the same delay (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp0_o   <= '0;
      comp1_o   <= '0;
      comp2_o   <= '0;
      de_o      <= 1'b0;
      hs_o      <= 1'b0;
      vs_o      <= 1'b0;
      pix_vld_o <= 1'b0;
    end else begin
      pix_vld_o <= nxt_load;
      if (nxt_load) begin
        comp0_o <= nxt_c0;
        comp1_o <= nxt_c1;
        comp2_o <= nxt_c2;
        de_o    <= nxt_sync.de;
        hs_o    <= nxt_sync.hs;
        vs_o    <= nxt_sync.vs;
      end
    end
  end

  AST_VLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_X2) |=> pix_vld_o); // R11

  AST_C2_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_FULL) |=> (comp2_o == '0)); // R3

  AST_DDR_SYNC_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DDR) |=> (de_o == $past(ddr_sync.de))); // R8

endmodule

// File: tb/sim_vcap_top.sv
`timescale 1ns/1ps
module sim_vcap_top;

  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode_i;
  logic [1:0]    just_i;
  logic          ddr_rise_first_i;
  logic [23:0]   bus_i;
  logic          de_i, hs_i, vs_i;
  logic [CW-1:0] comp0_o, comp1_o, comp2_o;
  logic          de_o, hs_o, vs_o, pix_vld_o;

  always #2 clk = ~clk;   // 250 MHz

  vcap_top u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .just_i(just_i),
    .ddr_rise_first_i(ddr_rise_first_i), .bus_i(bus_i),
    .de_i(de_i), .hs_i(hs_i), .vs_i(vs_i),
    .comp0_o(comp0_o), .comp1_o(comp1_o), .comp2_o(comp2_o),
    .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o), .pix_vld_o(pix_vld_o)
  );

  typedef struct {
    logic [CW-1:0] c0, c1, c2;
    logic          hs, vs;
    int            req, sreq;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;

  function automatic string rq(input int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";
      4: return "R4";   5: return "R5";   6: return "R6";
      7: return "R7";   8: return "R8";   9: return "R9";
      10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(input int r, input logic [63:0] act, input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq(r), what, act, exp);
    end
  endtask

  // bus encoders written from the layout rules, CW = 12
  function automatic logic [23:0] put_narrow(input logic [1:0] j, input logic [11:0] v);
    logic [23:0] b = '0;
    if (j == 2'd1)      b[11:0]  = v;
    else if (j == 2'd2) b[23:12] = v;
    else begin b[15:8] = v[11:4]; b[23:20] = v[3:0]; end
    return b;
  endfunction

  function automatic logic [23:0] put_wide(input logic [1:0] j, input logic [11:0] y, input logic [11:0] c);
    logic [23:0] b = '0;
    if (j == 2'd1 || j == 2'd2) b = {y, c};
    else begin
      b[15:8] = y[11:4]; b[7:0] = c[11:4];
      b[23:20] = y[3:0]; b[19:16] = c[3:0];
    end
    return b;
  endfunction

  task automatic push(input logic [11:0] a, input logic [11:0] b, input logic [11:0] c,
                      input logic h, input logic v, input int r, input int s);
    exp_t e;
    e.c0 = a; e.c1 = b; e.c2 = c; e.hs = h; e.vs = v; e.req = r; e.sreq = s;
    q.push_back(e);
  endtask

  // ---------------- monitor (scoreboard)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && pix_vld_o === 1'b1 && de_o === 1'b1) begin
      if (q.size() == 0) begin
        check(9, {63'd0, de_o}, 64'd0, "unexpected active pixel");
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.req, {28'd0, comp0_o, comp1_o, comp2_o},
              {28'd0, e.c0, e.c1, e.c2}, "components");
        check(e.sreq, {62'd0, hs_o, vs_o}, {62'd0, e.hs, e.vs}, "syncs");
      end
    end
  end

  // ---------------- driver
  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      de_i = 1'b0; hs_i = 1'($urandom); vs_i = 1'($urandom); bus_i = 24'($urandom);
    end
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [1:0] j, input logic l);
    @(posedge clk); #1;
    de_i = 1'b0; mode_i = m; just_i = j; ddr_rise_first_i = l;
    idle(4);
  endtask

  task automatic line_full(input int n);
    for (int k = 0; k < n; k++) begin
      logic [7:0] r, g, b;
      r = 8'($urandom); g = 8'($urandom); b = 8'($urandom);
      @(posedge clk); #1;
      bus_i = {r, g, b}; de_i = 1'b1; hs_i = 1'($urandom); vs_i = 1'($urandom);
      push({g, 4'h0}, {b, 4'h0}, {r, 4'h0}, hs_i, vs_i, 2, 9); // R2, syncs R9
    end
    idle(6);
  endtask

  task automatic line_wide(input int n, input logic [1:0] j, input int r, input int sw);
    for (int k = 0; k < n; k++) begin
      logic [11:0] y, c;
      y = 12'($urandom); c = 12'($urandom);
      @(posedge clk); #1;
      if (k == sw) mode_i = 2'd0;  // R10: change inside the line must not apply
      bus_i = put_wide(j, y, c); de_i = 1'b1; hs_i = 1'($urandom); vs_i = 1'($urandom);
      push(y, c, 12'h0, hs_i, vs_i, r, 9);
    end
    idle(6);
  endtask

  task automatic line_x2(input int n, input logic [1:0] j);
    for (int k = 0; k < n; k++) begin
      logic [11:0] y, c;
      y = 12'($urandom); c = 12'($urandom);
      @(posedge clk); #1;
      bus_i = put_narrow(j, c); de_i = 1'b1; hs_i = 1'($urandom); vs_i = 1'($urandom);
      @(posedge clk); #1;
      bus_i = put_narrow(j, y); hs_i = 1'($urandom); vs_i = 1'($urandom);
      push(y, c, 12'h0, hs_i, vs_i, (j == 2'd0) ? 5 : 4, 9); // R5 pairing, R4 layout
    end
    idle(6);
  endtask

  task automatic line_ddr(input int n, input logic [1:0] j, input logic lead);
    for (int k = 0; k < n; k++) begin
      logic [11:0] y, c;
      logic h, v;
      y = 12'($urandom); c = 12'($urandom);
      if (lead) begin                 // R6: chroma on rising half
        @(negedge clk); #1;
        bus_i = put_narrow(j, c); de_i = 1'b1; hs_i = 1'($urandom); vs_i = 1'($urandom);
        h = hs_i; v = vs_i;           // R8: rising half syncs
        @(posedge clk); #1;
        bus_i = put_narrow(j, y); hs_i = 1'($urandom); vs_i = 1'($urandom);
        push(y, c, 12'h0, h, v, 6, 8);
      end else begin                  // R7: chroma on falling half
        @(posedge clk); #1;
        bus_i = put_narrow(j, c); de_i = 1'b1; hs_i = 1'($urandom); vs_i = 1'($urandom);
        @(negedge clk); #1;
        bus_i = put_narrow(j, y); hs_i = 1'($urandom); vs_i = 1'($urandom);
        push(y, c, 12'h0, hs_i, vs_i, 7, 8);
      end
    end
    if (lead) begin @(negedge clk); #1; de_i = 1'b0; end
    idle(6);
  endtask

  task automatic vld_count(input int n, input int expect_n, input string what);
    int cnt = 0;
    repeat (n) begin @(negedge clk); cnt += int'(pix_vld_o); end
    check(11, 64'(cnt), 64'(expect_n), what); // R11
  endtask

  // ---------------- watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // ---------------- sequence
  initial begin
    rst_n = 1'b0; mode_i = 2'd0; just_i = 2'd0; ddr_rise_first_i = 1'b1;
    bus_i = 24'hFFFFFF; de_i = 1'b1; hs_i = 1'b1; vs_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(1, {25'd0, comp0_o, comp1_o, comp2_o, de_o, hs_o, vs_o, pix_vld_o},
            64'd0, "reset outputs"); // R1
    end
    @(posedge clk); #1;
    rst_n = 1'b1; de_i = 1'b0;

    set_cfg(2'd0, 2'd0, 1'b1);
    line_full(16);
    vld_count(4, 4, "mode0 strobe");

    for (int j = 0; j < 3; j++) begin
      set_cfg(2'd1, 2'(j), 1'b1);
      line_wide(12, 2'(j), 3, -1);    // R3
    end
    vld_count(4, 4, "mode1 strobe");

    set_cfg(2'd1, 2'd0, 1'b1);
    line_wide(10, 2'd0, 10, 3);       // R10
    mode_i = 2'd1;
    idle(4);

    for (int j = 0; j < 3; j++) begin
      set_cfg(2'd2, 2'(j), 1'b1);
      line_x2(10, 2'(j));
    end
    vld_count(8, 4, "mode2 strobe");

    for (int j = 0; j < 3; j++) begin
      set_cfg(2'd3, 2'(j), 1'b1);
      line_ddr(10, 2'(j), 1'b1);      // R6
    end
    set_cfg(2'd3, 2'd0, 1'b0);
    line_ddr(10, 2'd0, 1'b0);         // R7
    set_cfg(2'd3, 2'd2, 1'b0);
    line_ddr(10, 2'd2, 1'b0);
    vld_count(4, 4, "mode3 strobe");

    idle(8);
    check(9, 64'(q.size()), 64'd0, "pixels left unseen"); // R9
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule